// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block recovers characters from an asynchronous serial line whose idle level is high. A free-running oversampling strobe, sixteen pulses per bit period, paces it. The line first passes through a flop synchronizer. A falling level seen on a strobe starts a frame. The start is confirmed at the middle of the bit, and every later bit is sampled at its own centre. The frame shape is chosen at run time: five to nine data bits, optional even or odd parity, and any number of stop bits from the transmitter. Only the first stop bit is examined.

At the first stop bit sample the block presents the character right-aligned in a nine-bit word, together with a one-cycle valid strobe and the parity and framing error flags. The format inputs are captured when a start is detected, so a format change never disturbs a frame already in flight. After a framing error the receiver waits for the line to return high before it looks for the next start bit. This keeps a held-low line (a break) from producing a stream of phantom characters.

Top module: `serial_frame_rx`

## Requirements
- R1: The serial input passes through a two-flop synchronizer. A new frame is detected when the synchronized line reads low on an oversampling strobe while the receiver is idle.
- R2: A start bit is kept only if the line still reads low on the 8th strobe after detection. Otherwise the receiver returns to idle and produces no output.
- R3: Data bits are taken least significant first. Each bit is sampled 16 strobes after the previous sample. The bit count is `cfg_len`, with values below 5 treated as 5 and values above 9 treated as 9.
- R4: `rx_data` holds the character right-aligned. Bits at and above the character length are zero.
- R5: `cfg_par[1]` enables a parity bit and `cfg_par[0]` selects odd (1) or even (0). When enabled, the bit after the last data bit is the parity bit. `rx_perr` is set when it differs from the XOR of the data bits (inverted for odd). `rx_perr` is 0 when parity is disabled.
- R6: `rx_ferr` is set exactly when the first stop bit samples low. A second stop slot is never examined: a low level there raises no error on the current frame and is taken as the start of a new frame.
- R7: `rx_valid` is a single-cycle pulse issued one cycle after the first stop bit sample. `rx_data`, `rx_perr` and `rx_ferr` change only together with that pulse and hold until the next one.
- R8: `cfg_len` and `cfg_par` are captured at start detection. Changes during a frame affect only later frames.
- R9: After a frame error the receiver detects no new start until the line has read high.
- R10: After reset `rx_valid`, `rx_data`, `rx_perr` and `rx_ferr` are all 0.
- R11: Frames sent back to back with a single stop bit and no idle time are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 4 | Data bits per character (5 to 9, clamped) |
| cfg_par | input | 2 | Parity: bit 1 enable, bit 0 odd select |
| rx_data | output | 9 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| rx_perr | output | 1 | Parity mismatch on the last character |
| rx_ferr | output | 1 | First stop bit read low on the last character |

## Verification
The assertions assume two things about the inputs. First, `tick` is a single-cycle pulse arriving at a steady rate. Second, the line holds each bit for sixteen strobe periods, so that a centre sample is meaningful. The stimulus meets both. It raises `tick` on every fourth clock and holds each serial bit for exactly sixteen strobe periods, 64 clocks. It changes the format inputs mid-frame only in the one scenario that checks the capture rule. Glitches, breaks and a low second stop slot are produced only as whole or partial bit periods of the same length.

// File: rtl/frx_pkg.sv
package frx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BREAK
  } frx_state_t;
endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/frx_parity.sv
module frx_parity #(
  parameter int W = 9
) (
  input  logic [W-1:0] data,
  input  logic         pbit,
  input  logic         en,
  input  logic         odd,
  output logic         mismatch
);
  // data bits above the character length are zero, so the full-width XOR is exact
  assign mismatch = en & (pbit ^ (^data) ^ odd);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import frx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 9,
  parameter int SYNC_STAGES = 2,
  localparam int CW  = $clog2(OVS),
  localparam int MID = OVS / 2,
  localparam int LW  = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                rx_line,
  input  logic [LW-1:0]       cfg_len,
  input  logic [1:0]          cfg_par,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                rx_perr,
  output logic                rx_ferr
);
  frx_state_t          state;
  logic                line;
  logic [CW-1:0]       cnt;
  logic [LW-1:0]       idx;
  logic [LW-1:0]       len_q;
  logic [LW-1:0]       len_cl;
  logic [1:0]          par_q;
  logic [MAX_BITS-1:0] shreg;
  logic                pbit;
  logic                perr_w;
  logic                mid_hit;
  logic                full_hit;

  frx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .dout(line)
  );

  frx_parity #(.W(MAX_BITS)) u_par (
    .data    (shreg),
    .pbit    (pbit),
    .en      (par_q[1]),
    .odd     (par_q[0]),
    .mismatch(perr_w)
  );

  always_comb begin
    if (cfg_len < LW'(MIN_BITS))      len_cl = LW'(MIN_BITS);
    else if (cfg_len > LW'(MAX_BITS)) len_cl = LW'(MAX_BITS);
    else                              len_cl = cfg_len;
  end

  assign mid_hit  = tick && (cnt == CW'(MID - 1));
  assign full_hit = tick && (cnt == CW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      len_q    <= LW'(MIN_BITS);
      par_q    <= 2'b00;
      shreg    <= '0;
      pbit     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tick && !line) begin
            state <= ST_START;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            len_q <= len_cl;
            par_q <= cfg_par;
          end
        end
        ST_START: begin
          if (mid_hit) begin
            cnt   <= '0;
            state <= line ? ST_IDLE : ST_DATA;
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_DATA: begin
          if (full_hit) begin
            cnt        <= '0;
            shreg[idx] <= line;
            if (idx == len_q - LW'(1)) state <= par_q[1] ? ST_PAR : ST_STOP;
            else                       idx   <= idx + LW'(1);
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_PAR: begin
          if (full_hit) begin
            cnt   <= '0;
            pbit  <= line;
            state <= ST_STOP;
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_STOP: begin
          if (full_hit) begin
            cnt      <= '0;
            rx_valid <= 1'b1;
            rx_data  <= shreg;
            rx_perr  <= perr_w;
            rx_ferr  <= !line;
            state    <= line ? ST_IDLE : ST_BREAK;
          end else if (tick) begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_BREAK: begin
          if (line) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: strobe lasts one cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7: strobe only follows a stop-bit sample
  a_r7_valid_after_stop: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(state) == ST_STOP);

  // R4: unused upper bits cleared
  a_r4_upper_clear: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_data >> len_q) == '0));

  // R5: no parity error without a parity bit
  a_r5_no_perr_when_off: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !par_q[1]) |-> !rx_perr);

  // R2: start qualification never runs past mid-bit
  a_r2_start_window: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START) |-> (cnt < CW'(MID)));

  // R9: break state left only on a high line
  a_r9_break_exit: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_BREAK && state != ST_BREAK) |-> $past(line));
endmodule

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rx_line = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic [1:0] cfg_par = 2'b00;
  logic [8:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr;

  int n_chk = 0, n_bad = 0, nv = 0;
  logic [8:0] cap_d [0:3];
  logic       cap_p [0:3];
  logic       cap_f [0:3];
  logic [1:0] tcnt = 2'd0;
  bit         done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= tcnt + 2'd1;
    tick <= (tcnt == 2'd3);
  end

  serial_frame_rx dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_par(cfg_par),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (nv < 4) begin
        cap_d[nv] = rx_data;
        cap_p[nv] = rx_perr;
        cap_f[nv] = rx_ferr;
      end
      nv = nv + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitx(input logic v, input int clocks = BITCLK);
    rx_line = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int len, input logic [1:0] par,
                      input bit flip, input bit s1, input int nstop, input bit s2,
                      input bit midchg);
    logic [8:0] m;
    m = d & ((9'h1 << len) - 9'h1);
    bitx(1'b0);
    if (midchg) begin
      cfg_len = 4'd5;
      cfg_par = 2'b11;
    end
    for (int i = 0; i < len; i++) bitx(m[i]);
    if (par[1]) bitx((^m) ^ par[0] ^ flip);
    bitx(s1);
    if (nstop == 2) bitx(s2);
  endtask

  task automatic settle(input int bits);
    rx_line = 1'b1;
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 valid", int'(rx_valid), 0);
    chk("R10 data", int'(rx_data), 0);
    chk("R10 perr", int'(rx_perr), 0);
    chk("R10 ferr", int'(rx_ferr), 0);
  endtask

  task automatic t_basic();
    nv = 0; cfg_len = 4'd8; cfg_par = 2'b00;
    send(9'h0A5, 8, 2'b00, 0, 1, 1, 1, 0);
    settle(2);
    chk("R1 R7 count", nv, 1);
    chk("R3 data", int'(cap_d[0]), 'hA5);
    chk("R6 ferr clean", int'(cap_f[0]), 0);
    chk("R7 data held", int'(rx_data), 'hA5);
  endtask

  task automatic t_lengths();
    nv = 0; cfg_par = 2'b00;
    cfg_len = 4'd9;
    send(9'h1FF, 9, 2'b00, 0, 1, 1, 1, 0);
    settle(2);
    chk("R3 len9", int'(cap_d[0]), 'h1FF);
    for (int l = 5; l <= 8; l++) begin
      nv = 0; cfg_len = 4'(l);
      send(9'h16A, l, 2'b00, 0, 1, 1, 1, 0);
      settle(2);
      chk("R4 len data", int'(cap_d[0]), int'(9'h16A & ((9'h1 << l) - 9'h1)));
    end
    nv = 0; cfg_len = 4'd3;
    send(9'h015, 5, 2'b00, 0, 1, 1, 1, 0);
    settle(2);
    chk("R3 clamp low", int'(cap_d[0]), 'h15);
  endtask

  task automatic t_parity();
    logic [1:0] pm;
    cfg_len = 4'd7;
    for (int k = 0; k < 4; k++) begin
      nv = 0;
      pm = (k < 2) ? 2'b10 : 2'b11;
      cfg_par = pm;
      send(9'h05B, 7, pm, k[0], 1, 1, 1, 0);
      settle(2);
      chk("R5 data", int'(cap_d[0]), 'h5B);
      chk("R5 perr", int'(cap_p[0]), k % 2);
    end
  endtask

  task automatic t_ferr();
    nv = 0; cfg_len = 4'd8; cfg_par = 2'b00;
    send(9'h03C, 8, 2'b00, 0, 0, 1, 1, 0);
    bitx(1'b0, 3 * BITCLK);
    settle(3);
    chk("R6 ferr count R9", nv, 1);
    chk("R6 ferr set", int'(cap_f[0]), 1);
    chk("R7 ferr held", int'(rx_ferr), 1);
    nv = 0;
    send(9'h081, 8, 2'b00, 0, 1, 1, 1, 0);
    settle(2);
    chk("R9 recovery data", int'(cap_d[0]), 'h81);
    chk("R6 ferr cleared", int'(cap_f[0]), 0);
  endtask

  task automatic t_stop2();
    nv = 0; cfg_len = 4'd6; cfg_par = 2'b00;
    send(9'h012, 6, 2'b00, 0, 1, 2, 0, 0);
    settle(10);
    chk("R6 second stop count", nv, 2);
    chk("R6 second stop data", int'(cap_d[0]), 'h12);
    chk("R6 second stop no ferr", int'(cap_f[0]), 0);
    chk("R6 new start data", int'(cap_d[1]), 'h3F);
  endtask

  task automatic t_glitch();
    nv = 0; cfg_len = 4'd8;
    bitx(1'b0, 16);
    settle(12);
    chk("R2 glitch rejected", nv, 0);
  endtask

  task automatic t_latch();
    nv = 0; cfg_len = 4'd8; cfg_par = 2'b00;
    send(9'h0C3, 8, 2'b00, 0, 1, 1, 1, 1);
    settle(2);
    chk("R8 latched data", int'(cap_d[0]), 'hC3);
    chk("R8 latched no perr", int'(cap_p[0]), 0);
    cfg_len = 4'd8; cfg_par = 2'b00;
  endtask

  task automatic t_b2b();
    nv = 0; cfg_len = 4'd8; cfg_par = 2'b10;
    send(9'h055, 8, 2'b10, 0, 1, 1, 1, 0);
    send(9'h0F0, 8, 2'b10, 0, 1, 1, 1, 0);
    send(9'h001, 8, 2'b10, 0, 1, 1, 1, 0);
    settle(2);
    chk("R11 count", nv, 3);
    chk("R11 first", int'(cap_d[0]), 'h55);
    chk("R11 second", int'(cap_d[1]), 'hF0);
    chk("R11 third", int'(cap_d[2]), 'h01);
    chk("R11 perr", int'(cap_p[2]), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    settle(1);
    t_basic();
    t_lengths();
    t_parity();
    t_ferr();
    t_stop2();
    t_glitch();
    t_latch();
    t_b2b();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule